// File: doc/BRIEF.md
# Circular Message-Frame Queue Manager

This block keeps four circular queues of 32-bit message-frame addresses in a small internal word RAM. Queue 0 holds inbound free frames, queue 1 inbound posted frames, queue 2 outbound free frames and queue 3 outbound posted frames. Each queue has a head pointer, where entries are added, and a tail pointer, where entries are removed. A queue is empty when its head equals its tail.

A remote host uses two port addresses. At each of them a read removes an entry from one queue and a write adds an entry to a different queue. The local processor uses pointer registers at fixed addresses to read and move any head or tail. It uses a separate word port into the RAM to fill or drain entries. A control register enables the queues and selects the ring length. A base register sets the 1 MB-aligned address that is reported in pointer reads. Not-empty flags and one-cycle overflow pulses go to an interrupt unit.

Frames may be returned to a free queue in any order. The block records only the addresses it is given.

Top module: `mfq_ring_mgr`

## Requirements
- R1: After reset all pointers, the control register, the base register, `bus_rdata`, `mem_rdata`, `q_nempty` and `q_ovf` are zero.
- R2: The base register at 0x170 keeps write bits [31:20] and reads back with bits [19:0] zero. The control register at 0x164 keeps bit 0 (enable) and bits [5:1] (size code) and reads back with the other bits zero. A read of an unmapped address returns zero. `bus_rdata` is updated one cycle after a bus read and holds its value at all other times.
- R3: The pointer registers are laid out as follows. Queue q's head is at 0x120+0x10*q and its tail is at 0x128+0x10*q. Each reads as base | ((q*N + index)*4), where N is the ring length. A write stores (wdata>>2) mod N.
- R4: A read of 0x040 while enabled and queue 0 is not empty returns the entry at queue 0's tail and advances that tail by one, modulo N.
- R5: A write to 0x040 while enabled stores the data at queue 1's head and advances that head by one, modulo N.
- R6: A read of 0x044 removes an entry from queue 3 in the same way as R4. A write to 0x044 adds an entry to queue 2 in the same way as R5.
- R7: A port read from an empty queue returns 0xFFFFFFFF and leaves the tail unchanged.
- R8: While the enable bit is clear, port reads return 0xFFFFFFFF, and port writes change neither the pointers nor the flags.
- R9: The overflow flags are `q_ovf[0]` for queue 1 and `q_ovf[1]` for queue 2. A port write made when (head+1) mod N equals the tail raises the matching flag for exactly the cycle after the write. The entry is still stored and the head still advances.
- R10: `q_nempty[q]` is high exactly when queue q's head and tail differ modulo the current N.
- R11: A one-hot size code with bit k set (bits [5:1] of the control register) selects N = 2*ENTRY_UNIT*2^k. Any other code selects N = 2*ENTRY_UNIT. Stored pointers are taken modulo the current N.
- R12: Queue q's entry i occupies RAM word q*N + i. A write on the memory port takes effect at the clock edge. A read on the memory port returns the word on `mem_rdata` one cycle later, and `mem_rdata` holds at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of register or port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| mem_req | input | 1 | RAM word-port strobe |
| mem_we | input | 1 | RAM write enable |
| mem_addr | input | MAW | RAM word index |
| mem_wdata | input | 32 | RAM write data |
| mem_rdata | output | 32 | RAM read data, one cycle after the read |
| q_nempty | output | 4 | Per-queue not-empty flags |
| q_ovf | output | 2 | Overflow pulses: bit 0 for inbound post, bit 1 for outbound free |

## Verification
The assertions assume that at most one register access arrives per cycle, as the single strobe implies. They also assume that a bus port write and a memory-port access never target the same RAM word in the same cycle. The stimulus keeps to this by placing every memory-port access in a cycle with no bus operation. After every size change the stimulus rewrites the pointers before it removes any entry, so no read depends on RAM words that were never written. Power-of-two values of ENTRY_UNIT are assumed for the word-index arithmetic.

// File: rtl/mfq_ring_mgr.sv
module mfq_ring_mgr #(
  parameter int ENTRY_UNIT = 2,
  parameter int AW = 12,
  parameter int MAW = $clog2(4 * 32 * ENTRY_UNIT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_req,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic           mem_req,
  input  logic           mem_we,
  input  logic [MAW-1:0] mem_addr,
  input  logic [31:0]    mem_wdata,
  output logic [31:0]    mem_rdata,
  output logic [3:0]     q_nempty,
  output logic [1:0]     q_ovf
);
  localparam int NMAX = 32 * ENTRY_UNIT;
  localparam int IW = $clog2(NMAX);
  localparam int MWORDS = 4 * NMAX;
  localparam logic [AW-1:0] A_INQ  = AW'('h040);
  localparam logic [AW-1:0] A_OUTQ = AW'('h044);
  localparam logic [AW-1:0] A_CTRL = AW'('h164);
  localparam logic [AW-1:0] A_BASE = AW'('h170);

  logic [31:0]    ram [MWORDS];
  logic [IW-1:0]  hd [4];
  logic [IW-1:0]  tl [4];
  logic           en;
  logic [4:0]     szc;
  logic [11:0]    qbase;

  logic [2:0]     shamt;
  logic [IW:0]    ents;
  logic [IW-1:0]  msk;
  logic [IW-1:0]  he [4];
  logic [IW-1:0]  te [4];
  logic [MAW-1:0] qoff [4];

  always_comb begin
    shamt = '0;
    for (int k = 0; k < 5; k++)
      if (szc == 5'(1 << k)) shamt = 3'(k);
  end
  assign ents = (IW+1)'(2 * ENTRY_UNIT) << shamt;
  assign msk  = IW'(ents - 1'b1);

  generate
    for (genvar g = 0; g < 4; g++) begin : g_q
      assign he[g] = hd[g] & msk;
      assign te[g] = tl[g] & msk;
      assign qoff[g] = MAW'(g) * MAW'(ents);
      assign q_nempty[g] = he[g] != te[g];
    end
  endgenerate

  logic rd, wr, hit_in, hit_out, hit_port, hit_ptr, hit_ctrl, hit_base, ptr_tail;
  logic [1:0] ptr_q, pop_q, push_q;
  logic pop_req, pop_go, push_go, push_ovf;
  logic [31:0] ptr_val, rd_next;

  assign rd       = bus_req & ~bus_we;
  assign wr       = bus_req & bus_we;
  assign hit_in   = bus_addr == A_INQ;
  assign hit_out  = bus_addr == A_OUTQ;
  assign hit_port = hit_in | hit_out;
  assign hit_ctrl = bus_addr == A_CTRL;
  assign hit_base = bus_addr == A_BASE;
  assign hit_ptr  = (bus_addr[AW-1:8] == (AW-8)'(1)) && (bus_addr[7:4] >= 4'h2)
                    && (bus_addr[7:4] <= 4'h5) && (bus_addr[2:0] == 3'b000);
  assign ptr_q    = 2'(bus_addr[7:4] - 4'h2);
  assign ptr_tail = bus_addr[3];

  assign pop_q    = hit_out ? 2'd3 : 2'd0;
  assign push_q   = hit_out ? 2'd2 : 2'd1;
  assign pop_req  = rd & en & hit_port;
  assign pop_go   = pop_req & (he[pop_q] != te[pop_q]);
  assign push_go  = wr & en & hit_port;
  assign push_ovf = (IW'(he[push_q] + 1'b1) & msk) == te[push_q];

  assign ptr_val = 32'(qoff[ptr_q]) + 32'(ptr_tail ? te[ptr_q] : he[ptr_q]);

  always_comb begin
    if (hit_port)      rd_next = pop_go ? ram[qoff[pop_q] + MAW'(te[pop_q])] : '1;
    else if (hit_ptr)  rd_next = {qbase, 20'b0} | (ptr_val << 2);
    else if (hit_ctrl) rd_next = {26'b0, szc, en};
    else if (hit_base) rd_next = {qbase, 20'b0};
    else               rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        hd[i] <= '0;
        tl[i] <= '0;
      end
      en        <= 1'b0;
      szc       <= '0;
      qbase     <= '0;
      bus_rdata <= '0;
      mem_rdata <= '0;
      q_ovf     <= '0;
    end else begin
      q_ovf <= '0;
      if (rd) bus_rdata <= rd_next;
      if (mem_req && !mem_we) mem_rdata <= ram[mem_addr];
      if (pop_go) tl[pop_q] <= IW'(te[pop_q] + 1'b1) & msk;
      if (push_go) begin
        hd[push_q] <= IW'(he[push_q] + 1'b1) & msk;
        q_ovf <= {push_ovf & hit_out, push_ovf & hit_in};
      end
      if (wr && hit_ptr) begin
        if (ptr_tail) tl[ptr_q] <= bus_wdata[IW+1:2] & msk;
        else          hd[ptr_q] <= bus_wdata[IW+1:2] & msk;
      end
      if (wr && hit_ctrl) begin
        en  <= bus_wdata[0];
        szc <= bus_wdata[5:1];
      end
      if (wr && hit_base) qbase <= bus_wdata[31:20];
    end
  end

  always_ff @(posedge clk) begin
    if (mem_req && mem_we) ram[mem_addr] <= mem_wdata;
    if (push_go) ram[qoff[push_q] + MAW'(he[push_q])] <= bus_wdata;
  end

  p_empty_alloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && en && hit_in && !q_nempty[0]) |=> (bus_rdata == 32'hFFFF_FFFF) && $stable(tl[0]));

  p_disabled_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !en && hit_port) |=> bus_rdata == 32'hFFFF_FFFF);

  p_disabled_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !en && hit_port) |=> $stable(hd[1]) && $stable(hd[2]) && q_ovf == 2'b00);

  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_ovf[0] |-> $past(wr && en && hit_in));

  p_ovf_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_ovf));

  p_push_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && en && hit_in) |=> q_nempty[1] || q_ovf[0]);

  p_pop_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && en && hit_in && q_nempty[0]) |=> tl[0] == (IW'($past(te[0]) + 1'b1) & $past(msk)));
endmodule

// File: tb/mfq_ring_mgr_test.sv
module mfq_ring_mgr_test;
  localparam int U = 2;
  localparam int MW = 4 * 32 * U;
  localparam int MAW = $clog2(MW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mem_req = 1'b0, mem_we = 1'b0;
  logic [MAW-1:0] mem_addr = '0;
  logic [31:0] mem_wdata = '0, mem_rdata;
  logic [3:0] q_nempty;
  logic [1:0] q_ovf;

  always #5 clk = ~clk;

  mfq_ring_mgr #(.ENTRY_UNIT(U), .AW(12), .MAW(MAW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .q_nempty(q_nempty), .q_ovf(q_ovf));

  int checks = 0, failures = 0;
  int m_hd[4], m_tl[4];
  logic [31:0] m_mem [MW];
  bit m_en = 0;
  int m_szc = 0;
  logic [11:0] m_base = '0;
  logic [31:0] e_rd = '0, e_mrd = '0;
  logic [1:0] e_ovf = '0;

  function automatic int nn();
    for (int k = 0; k < 5; k++) if (m_szc == (1 << k)) return (2 * U) << k;
    return 2 * U;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit breq, input bit bwe, input logic [11:0] a, input logic [31:0] d,
                      input bit mrq, input bit mwe, input int ma, input logic [31:0] md, input string tag);
    int n, q, h, idx;
    logic [3:0] ene;
    @(negedge clk);
    bus_req = breq; bus_we = bwe; bus_addr = a; bus_wdata = d;
    mem_req = mrq; mem_we = mwe; mem_addr = MAW'(ma); mem_wdata = md;
    n = nn();
    e_ovf = '0;
    if (mrq) begin
      if (mwe) m_mem[ma] = md; else e_mrd = m_mem[ma];
    end
    if (breq && !bwe) begin
      if (a == 12'h040 || a == 12'h044) begin
        q = (a == 12'h040) ? 0 : 3;
        if (!m_en || (m_hd[q] % n) == (m_tl[q] % n)) e_rd = 32'hFFFF_FFFF;
        else begin
          e_rd = m_mem[q * n + m_tl[q] % n];
          m_tl[q] = (m_tl[q] % n + 1) % n;
        end
      end else if (a >= 12'h120 && a <= 12'h158 && a[2:0] == 3'b000) begin
        q = int'(a[7:4]) - 2;
        idx = a[3] ? m_tl[q] % n : m_hd[q] % n;
        e_rd = {m_base, 20'b0} | 32'((q * n + idx) * 4);
      end else if (a == 12'h164) e_rd = {26'b0, 5'(m_szc), m_en};
      else if (a == 12'h170) e_rd = {m_base, 20'b0};
      else e_rd = '0;
    end else if (breq) begin
      if (a == 12'h040 || a == 12'h044) begin
        if (m_en) begin
          q = (a == 12'h040) ? 1 : 2;
          h = m_hd[q] % n;
          if ((h + 1) % n == m_tl[q] % n) e_ovf[q == 1 ? 0 : 1] = 1'b1;
          m_mem[q * n + h] = d;
          m_hd[q] = (h + 1) % n;
        end
      end else if (a >= 12'h120 && a <= 12'h158 && a[2:0] == 3'b000) begin
        q = int'(a[7:4]) - 2;
        if (a[3]) m_tl[q] = int'(d >> 2) % n; else m_hd[q] = int'(d >> 2) % n;
      end else if (a == 12'h164) begin
        m_en = d[0];
        m_szc = int'(d[5:1]);
      end else if (a == 12'h170) m_base = d[31:20];
    end
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; mem_req = 1'b0;
    n = nn();
    for (int i = 0; i < 4; i++) ene[i] = (m_hd[i] % n) != (m_tl[i] % n);
    chk(bus_rdata, e_rd, tag, "bus_rdata");
    chk(mem_rdata, e_mrd, "R12", "mem_rdata");
    chk({30'b0, q_ovf}, {30'b0, e_ovf}, "R9", "q_ovf");
    chk({28'b0, q_nempty}, {28'b0, ene}, "R10", "q_nempty");
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step(1, 0, a, '0, 0, 0, 0, '0, tag);
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(1, 1, a, d, 0, 0, 0, '0, tag);
  endtask
  task automatic mw(input int ma, input logic [31:0] md);
    step(0, 0, '0, '0, 1, 1, ma, md, "R12");
  endtask
  task automatic mr(input int ma);
    step(0, 0, '0, '0, 1, 0, ma, '0, "R12");
  endtask

  initial begin
    #2_000_000;
    failures++;
    checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_hd[i] = 0; m_tl[i] = 0; end
    for (int i = 0; i < MW; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    step(0, 0, '0, '0, 0, 0, 0, '0, "R1");
    rd(12'h164, "R1");
    rd(12'h170, "R1");
    for (int q = 0; q < 4; q++) begin
      rd(12'(12'h120 + 16 * q), "R1");
      rd(12'(12'h128 + 16 * q), "R1");
    end

    rd(12'h040, "R8");
    wr(12'h040, 32'h5555_0001, "R8");
    wr(12'h044, 32'h5555_0002, "R8");
    rd(12'h130, "R8");
    rd(12'h140, "R8");

    wr(12'h170, 32'h1230_0ABC, "R2");
    rd(12'h170, "R2");
    wr(12'h164, 32'hFFFF_FF03, "R2");
    rd(12'h164, "R2");
    rd(12'h0F0, "R2");

    rd(12'h040, "R7");
    for (int i = 0; i < 3; i++) mw(i, 32'hA000_0000 + 32'(i * 16));
    wr(12'h120, 32'h1230_000C, "R3");
    rd(12'h120, "R3");
    for (int i = 0; i < 3; i++) rd(12'h040, "R4");
    rd(12'h040, "R7");
    rd(12'h128, "R4");

    for (int i = 0; i < 5; i++) wr(12'h040, 32'hB000_0000 + 32'(i), "R5");
    rd(12'h130, "R3");
    rd(12'h138, "R3");
    for (int i = 0; i < 4; i++) mr(4 + i);
    wr(12'h138, 32'h1230_0018, "R3");
    rd(12'h138, "R3");

    wr(12'h044, 32'hC000_0300, "R6");
    wr(12'h044, 32'hC000_0100, "R6");
    wr(12'h044, 32'hC000_0200, "R6");
    wr(12'h044, 32'hC000_0400, "R9");
    rd(12'h140, "R6");
    for (int i = 0; i < 4; i++) mr(8 + i);
    mw(12, 32'hD000_0001);
    mw(13, 32'hD000_0002);
    wr(12'h150, 32'h1230_0038, "R6");
    for (int i = 0; i < 3; i++) rd(12'h044, "R6");
    rd(12'h158, "R6");

    wr(12'h164, 32'h0000_0009, "R11");
    rd(12'h164, "R11");
    for (int q = 0; q < 4; q++) rd(12'(12'h120 + 16 * q), "R11");
    wr(12'h130, 32'h1230_0000, "R11");
    wr(12'h138, 32'h1230_0000, "R11");
    for (int i = 0; i < 18; i++) wr(12'h040, 32'hE000_0000 + 32'(i), "R11");
    rd(12'h130, "R11");
    for (int i = 0; i < 3; i++) mr(16 + i);
    wr(12'h164, 32'h0000_0007, "R11");
    rd(12'h130, "R11");
    rd(12'h164, "R11");

    wr(12'h148, 32'hFFFF_FFFF, "R3");
    rd(12'h148, "R3");
    wr(12'h164, 32'h0000_0020, "R8");
    wr(12'h044, 32'h7777_0000, "R8");
    rd(12'h140, "R8");
    rd(12'h044, "R8");
    rd(12'h040, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule